// File: doc/BRIEF.md
# DMA Thread Event and Interrupt Unit

This unit holds a bank of event lines that the threads of a DMA engine use to signal one another or the host processor. A thread that issues a send-event names one line. The line's enable bit picks its role: an enabled line latches a masked interrupt status bit and drives its own interrupt output toward the host. A line that is not enabled stays a pending internal event, which a later wait-for-event on the same line can consume.

Wait-for-event requests come with the requesting thread's number. When the named line is pending and not interrupt-enabled, the request proceeds in the same cycle and consumes the pending bit. Every other thread parked on that same line is released at the same moment. Otherwise the thread is recorded as waiting, together with the id it waits for. The scheduler re-issues the request later.

Both request kinds are range checked against the configured event count. They are also checked against a per-line permission mask that applies to non-secure requesters. A rejected request returns a fault code and has no effect. The host sees the lines through four 32-bit registers: enable, raw status, masked status and a write-to-clear register.

Top module: `evt_irq_unit`

## Requirements
- R1: The event id is bits [7:3] of the request operand. An id at or above NUM_EV (default 16) returns fault code 8'h02 (bit 1) in the same cycle, and the request changes no state, including the requesting thread's waiting state and wake id.
- R2: A request with its non-secure flag set, whose line has a clear bit in ev_ns_allow, returns fault code 8'h20 (bit 5) and changes no state. An out-of-range id reports only 8'h02. At most one fault bit is ever set.
- R3: An accepted send-event sets the line's raw status bit at the next clock edge. If the line's enable bit is set, the same edge also sets its masked status bit and its irq output.
- R4: An accepted wait-for-event raises wfe_go in the same cycle exactly when the line's raw bit is 1 and its enable bit is 0. In that case the raw bit is cleared at the next edge.
- R5: An accepted wait-for-event that does not proceed sets thr_waiting for the requesting thread at the next edge. It also records the id in that thread's 5-bit field of thr_wake_id, at bits [5t+4:5t].
- R6: A proceeding wait-for-event clears thr_waiting for its own thread. It also clears thr_waiting for every waiting thread whose recorded id equals the request's id. Threads waiting on other ids stay waiting.
- R7: A write to the clear register acts only on bits set in both the written value and the enable register. Those bits are cleared in raw and masked status, and their irq outputs drop at the next edge. All other bits are unchanged.
- R8: Register offsets: enable 0x020 (read/write, bits at or above NUM_EV read 0), raw status 0x024, masked status 0x028, clear 0x02C. The clear register reads 0. Writes to 0x024 and 0x028 are ignored. Any other offset reads 0.
- R9: A send-event on a line wins over a clear write to the same bit, and over a proceeding wait-for-event on the same line, in the same cycle: the bit ends set.
- R10: After reset, all status and enable bits, irq outputs, waiting flags and recorded wake ids are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| ev_ns_allow | input | NUM_EV | Lines that non-secure requesters may use |
| sev_valid | input | 1 | Send-event request |
| sev_operand | input | 8 | Send-event operand; id in [7:3] |
| sev_ns | input | 1 | Send-event requester is non-secure |
| sev_fault | output | 8 | Send-event fault code, 0 when accepted |
| wfe_valid | input | 1 | Wait-for-event request |
| wfe_thread | input | THR_W | Requesting thread number |
| wfe_operand | input | 8 | Wait-for-event operand; id in [7:3] |
| wfe_ns | input | 1 | Wait-for-event requester is non-secure |
| wfe_fault | output | 8 | Wait-for-event fault code, 0 when accepted |
| wfe_go | output | 1 | The wait-for-event proceeds this cycle |
| irq | output | NUM_EV | One interrupt output per line |
| thr_waiting | output | NUM_THR | Thread is waiting for an event |
| thr_wake_id | output | 5*NUM_THR | Recorded wake id per thread |

## Verification
Two pairs of functions can land in the same cycle. A send-event can meet a host clear of the same bit, and a send-event can meet a proceeding wait-for-event on the same line. The bench provokes both by driving the colliding requests on one clock edge on a line already in the right state: enabled for the clear collision, pending and not enabled for the wait collision. It judges the outcome at the next falling edge against a behavioural model that applies the send after the clear and after the consumption. The proceed decision is also compared within the request's own cycle, so a model that reads post-edge state would disagree.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int OPER_W   = 8;
   localparam int ID_W     = 5;
   localparam int REG_W    = 32;
   localparam int FAULT_W  = 8;
   localparam int FB_RANGE = 1;
   localparam int FB_SECUR = 5;
   localparam int OFS_EN   = 'h020;
   localparam int OFS_RAW  = 'h024;
   localparam int OFS_MIS  = 'h028;
   localparam int OFS_CLR  = 'h02C;

   typedef struct packed {
      logic               ok;
      logic [ID_W-1:0]    id;
      logic [FAULT_W-1:0] fault;
   } evt_req_t;
endpackage

// File: rtl/evt_req_check.sv
module evt_req_check
   import evt_irq_pkg::*;
#(
   parameter int NUM_EV = 16
) (
   input  logic [ID_W-1:0]   ev_field,
   input  logic              ns,
   input  logic [NUM_EV-1:0] ns_allow,
   output evt_req_t          res
);
   logic [REG_W-1:0] allow_pad;

   always_comb begin
      allow_pad = '0;
      allow_pad[NUM_EV-1:0] = ns_allow;
      res.id    = ev_field;
      res.fault = '0;
      if (int'(ev_field) >= NUM_EV)
         res.fault[FB_RANGE] = 1'b1;
      else if (ns && !allow_pad[ev_field])
         res.fault[FB_SECUR] = 1'b1;
      res.ok = (res.fault == '0);
   end
endmodule

// File: rtl/evt_status_regs.sv
module evt_status_regs
   import evt_irq_pkg::*;
#(
   parameter int NUM_EV = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_we,
   input  logic [REG_W-1:0] en_wd,
   input  logic [REG_W-1:0] set_vec,
   input  logic [REG_W-1:0] consume_vec,
   input  logic [REG_W-1:0] clr_req,
   output logic [REG_W-1:0] en_q,
   output logic [REG_W-1:0] raw_q,
   output logic [REG_W-1:0] mis_q
);
   localparam logic [REG_W-1:0] VALID = REG_W'((64'd1 << NUM_EV) - 64'd1);

   logic [REG_W-1:0] clr_bits;
   assign clr_bits = clr_req & en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         raw_q <= '0;
         mis_q <= '0;
      end else begin
         if (en_we)
            en_q <= en_wd & VALID;
         raw_q <= ((raw_q & ~clr_bits & ~consume_vec) | set_vec) & VALID;
         mis_q <= ((mis_q & ~clr_bits) | (set_vec & en_q)) & VALID;
      end
   end
endmodule

// File: rtl/evt_waiters.sv
module evt_waiters
   import evt_irq_pkg::*;
#(
   parameter int NUM_THR = 8,
   localparam int THR_W  = $clog2(NUM_THR)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_ok,
   input  logic [THR_W-1:0]        req_thr,
   input  logic [ID_W-1:0]         req_id,
   input  logic                    req_go,
   output logic [NUM_THR-1:0]      waiting,
   output logic [NUM_THR*ID_W-1:0] wake_id
);
   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      logic            wait_q;
      logic [ID_W-1:0] id_q;
      logic            own_req;
      logic            peer_rel;

      assign own_req  = req_ok && (int'(req_thr) == t);
      assign peer_rel = req_ok && req_go && wait_q && (id_q == req_id);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wait_q <= 1'b0;
            id_q   <= '0;
         end else if (own_req) begin
            wait_q <= !req_go;
            id_q   <= req_id;
         end else if (peer_rel) begin
            wait_q <= 1'b0;
         end
      end

      assign waiting[t]                  = wait_q;
      assign wake_id[t*ID_W +: ID_W]     = id_q;
   end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
   import evt_irq_pkg::*;
#(
   parameter int NUM_EV  = 16,
   parameter int NUM_THR = 8,
   parameter int ADDR_W  = 12,
   localparam int THR_W  = $clog2(NUM_THR)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [31:0]             reg_wdata,
   output logic [31:0]             reg_rdata,
   input  logic [NUM_EV-1:0]       ev_ns_allow,
   input  logic                    sev_valid,
   input  logic [7:0]              sev_operand,
   input  logic                    sev_ns,
   output logic [7:0]              sev_fault,
   input  logic                    wfe_valid,
   input  logic [THR_W-1:0]        wfe_thread,
   input  logic [7:0]              wfe_operand,
   input  logic                    wfe_ns,
   output logic [7:0]              wfe_fault,
   output logic                    wfe_go,
   output logic [NUM_EV-1:0]       irq,
   output logic [NUM_THR-1:0]      thr_waiting,
   output logic [5*NUM_THR-1:0]    thr_wake_id
);
   if (NUM_EV < 1 || NUM_EV > REG_W) begin : g_bad_ev
      $error("evt_irq_unit: NUM_EV must lie in 1..32");
   end
   if (NUM_THR < 2) begin : g_bad_thr
      $error("evt_irq_unit: NUM_THR must be at least 2");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("evt_irq_unit: ADDR_W too small for the register offsets");
   end

   evt_req_t         sev_chk, wfe_chk;
   logic [REG_W-1:0] ev_en, ev_raw, ev_mis;
   logic [REG_W-1:0] set_vec, consume_vec, clr_req;
   logic             en_we, sev_acc, wfe_acc;
   logic             unused_oper_lo;

   assign unused_oper_lo = ^{sev_operand[2:0], wfe_operand[2:0]};

   evt_req_check #(.NUM_EV(NUM_EV)) u_sev_chk (
      .ev_field (sev_operand[7:3]),
      .ns       (sev_ns),
      .ns_allow (ev_ns_allow),
      .res      (sev_chk)
   );

   evt_req_check #(.NUM_EV(NUM_EV)) u_wfe_chk (
      .ev_field (wfe_operand[7:3]),
      .ns       (wfe_ns),
      .ns_allow (ev_ns_allow),
      .res      (wfe_chk)
   );

   assign sev_acc   = sev_valid && sev_chk.ok;
   assign wfe_acc   = wfe_valid && wfe_chk.ok;
   assign sev_fault = sev_valid ? sev_chk.fault : '0;
   assign wfe_fault = wfe_valid ? wfe_chk.fault : '0;
   assign wfe_go    = wfe_acc && ev_raw[wfe_chk.id] && !ev_en[wfe_chk.id];

   assign set_vec     = sev_acc ? (REG_W'(1) << sev_chk.id) : '0;
   assign consume_vec = wfe_go  ? (REG_W'(1) << wfe_chk.id) : '0;
   assign en_we       = reg_wr && (reg_addr == ADDR_W'(OFS_EN));
   assign clr_req     = (reg_wr && (reg_addr == ADDR_W'(OFS_CLR))) ? reg_wdata : '0;

   evt_status_regs #(.NUM_EV(NUM_EV)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_we       (en_we),
      .en_wd       (reg_wdata),
      .set_vec     (set_vec),
      .consume_vec (consume_vec),
      .clr_req     (clr_req),
      .en_q        (ev_en),
      .raw_q       (ev_raw),
      .mis_q       (ev_mis)
   );

   evt_waiters #(.NUM_THR(NUM_THR)) u_waiters (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_ok  (wfe_acc),
      .req_thr (wfe_thread),
      .req_id  (wfe_chk.id),
      .req_go  (wfe_go),
      .waiting (thr_waiting),
      .wake_id (thr_wake_id)
   );

   assign irq = ev_mis[NUM_EV-1:0];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_EN))       reg_rdata = ev_en;
      else if (reg_addr == ADDR_W'(OFS_RAW)) reg_rdata = ev_raw;
      else if (reg_addr == ADDR_W'(OFS_MIS)) reg_rdata = ev_mis;
   end
endmodule

// File: rtl/evt_irq_unit_chk.sv
module evt_irq_unit_chk
   import evt_irq_pkg::*;
#(
   parameter int NUM_EV  = 16,
   parameter int NUM_THR = 8,
   parameter int ADDR_W  = 12,
   localparam int THR_W  = $clog2(NUM_THR)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [31:0]        reg_wdata,
   input logic [31:0]        reg_rdata,
   input logic               sev_valid,
   input logic [7:0]         sev_operand,
   input logic [7:0]         sev_fault,
   input logic               wfe_valid,
   input logic [THR_W-1:0]   wfe_thread,
   input logic [7:0]         wfe_fault,
   input logic               wfe_go,
   input logic [NUM_THR-1:0] thr_waiting,
   input logic [31:0]        ev_en,
   input logic [31:0]        ev_raw,
   input logic [31:0]        ev_mis
);
   // R1: out-of-range id gives the range fault code only
   a_r1_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (sev_valid && int'(sev_operand[7:3]) >= NUM_EV) |-> (sev_fault == 8'h02));

   // R2: never more than one fault bit
   a_r2_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sev_fault) && $onehot0(wfe_fault));

   // R3: accepted send leaves the raw bit set
   a_r3_send_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
      (sev_valid && sev_fault == 8'h00) |=> ev_raw[$past(sev_operand[7:3])]);

   // R4: proceeding only on an accepted request
   a_r4_go_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      wfe_go |-> (wfe_valid && wfe_fault == 8'h00));

   // R5: a stalled wait parks the thread
   a_r5_thread_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (wfe_valid && wfe_fault == 8'h00 && !wfe_go) |=> thr_waiting[$past(wfe_thread)]);

   // R7: clear without a competing send empties the enabled bits
   a_r7_clear_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_CLR) && !sev_valid && !wfe_valid)
      |=> ((ev_mis & $past(reg_wdata & ev_en)) == 32'h0));

   // R8: clear register reads zero
   a_r8_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_CLR)) |-> (reg_rdata == 32'h0));

   // R10: masked status only holds bits set while reset is off
   a_r10_mis_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ev_mis == 32'h0 && ev_raw == 32'h0));
endmodule

bind evt_irq_unit evt_irq_unit_chk #(
   .NUM_EV(NUM_EV), .NUM_THR(NUM_THR), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/evt_irq_unit_bench.sv
`timescale 1ns/1ps
module evt_irq_unit_bench;
   localparam int NE = 16;
   localparam int NT = 8;
   localparam int AW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr;
   logic [AW-1:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [NE-1:0] ev_ns_allow = 16'h00FF;
   logic sev_valid, sev_ns, wfe_valid, wfe_ns, wfe_go;
   logic [7:0] sev_operand, wfe_operand, sev_fault, wfe_fault;
   logic [2:0] wfe_thread;
   logic [NE-1:0] irq;
   logic [NT-1:0] thr_waiting;
   logic [5*NT-1:0] thr_wake_id;

   int tests = 0, fails = 0;
   bit done = 0;

   // behavioural reference state
   bit [31:0] m_en, m_raw, m_mis;
   bit m_wait[NT];
   int m_wk[NT];

   always #10 clk = ~clk;

   evt_irq_unit #(.NUM_EV(NE), .NUM_THR(NT), .ADDR_W(AW)) u_evt_irq_unit (.*);

   task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic int m_fault(logic [7:0] op, logic ns);
      int id = int'(op[7:3]);
      if (id >= NE) return 8'h02;
      if (ns && !ev_ns_allow[id]) return 8'h20;
      return 0;
   endfunction

   function automatic logic [31:0] m_read(int a);
      case (a)
         'h020: return m_en;
         'h024: return m_raw;
         'h028: return m_mis;
         default: return 32'h0;
      endcase
   endfunction

   task automatic idle();
      reg_wr = 0; reg_addr = '0; reg_wdata = '0;
      sev_valid = 0; sev_operand = '0; sev_ns = 0;
      wfe_valid = 0; wfe_operand = '0; wfe_ns = 0; wfe_thread = '0;
   endtask

   // inputs are set by the caller at a falling edge
   task automatic cycle(string tag);
      int sf, wf, sid, wid;
      bit go;
      bit [31:0] clr, n_raw, n_mis, n_en;
      logic [5*NT-1:0] exp_wk;
      logic [NT-1:0] exp_wait;
      sf  = sev_valid ? m_fault(sev_operand, sev_ns) : 0;
      wf  = wfe_valid ? m_fault(wfe_operand, wfe_ns) : 0;
      sid = int'(sev_operand[7:3]);
      wid = int'(wfe_operand[7:3]);
      go  = wfe_valid && wf == 0 && m_raw[wid] && !m_en[wid];
      #1;
      check({tag, " sev_fault"}, 64'(sev_fault), 64'(sf));
      check({tag, " wfe_fault"}, 64'(wfe_fault), 64'(wf));
      check({tag, " wfe_go"}, 64'(wfe_go), 64'(go));
      @(posedge clk);
      clr   = (reg_wr && reg_addr == 'h02C) ? (reg_wdata & m_en) : 0;
      n_en  = (reg_wr && reg_addr == 'h020) ? (reg_wdata & 32'h0000FFFF) : m_en;
      n_raw = m_raw & ~clr;
      n_mis = m_mis & ~clr;
      if (go) n_raw[wid] = 0;
      if (sev_valid && sf == 0) begin
         n_raw[sid] = 1;
         if (m_en[sid]) n_mis[sid] = 1;
      end
      if (wfe_valid && wf == 0)
         for (int t = 0; t < NT; t++) begin
            if (t == int'(wfe_thread)) begin
               m_wait[t] = !go; m_wk[t] = wid;
            end else if (go && m_wait[t] && m_wk[t] == wid)
               m_wait[t] = 0;
         end
      m_en = n_en; m_raw = n_raw; m_mis = n_mis;
      @(negedge clk);
      for (int t = 0; t < NT; t++) begin
         exp_wait[t] = m_wait[t];
         exp_wk[t*5 +: 5] = 5'(m_wk[t]);
      end
      check({tag, " irq"}, 64'(irq), 64'(m_mis[NE-1:0]));
      check({tag, " waiting"}, 64'(thr_waiting), 64'(exp_wait));
      check({tag, " wake_id"}, 64'(thr_wake_id), 64'(exp_wk));
      idle();
   endtask

   task automatic rd(string tag, int a);
      reg_wr = 0; reg_addr = AW'(a);
      #1 check({tag, " rdata"}, 64'(reg_rdata), 64'(m_read(a)));
   endtask

   task automatic wr(int a, logic [31:0] d);
      reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
   endtask

   task automatic sev(int id, bit ns);
      sev_valid = 1; sev_operand = {5'(id), 3'b000}; sev_ns = ns;
   endtask

   task automatic wfe(int thr, int id, bit ns);
      wfe_valid = 1; wfe_thread = 3'(thr); wfe_operand = {5'(id), 3'b000}; wfe_ns = ns;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         tests++; fails++;
         $display("FAIL R10 watchdog got=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      idle();
      for (int t = 0; t < NT; t++) begin m_wait[t] = 0; m_wk[t] = 0; end
      m_en = 0; m_raw = 0; m_mis = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10 reset state
      rd("R10 en", 'h020); rd("R10 raw", 'h024); rd("R10 mis", 'h028);
      check("R10 irq", 64'(irq), 64'h0);
      check("R10 waiting", 64'(thr_waiting), 64'h0);
      check("R10 wake_id", 64'(thr_wake_id), 64'h0);
      // R3 send on a line used as an event, then on an interrupt line
      sev(3, 0); cycle("R3 event send");
      rd("R3 raw", 'h024);
      wr('h020, 32'hFFFF0020); cycle("R8 enable write");
      rd("R8 en masked", 'h020);
      sev(5, 0); cycle("R3 irq send");
      rd("R3 mis", 'h028);
      // R7 clear acts on enabled bits only
      wr('h02C, 32'hFFFFFFFF); cycle("R7 clear");
      rd("R7 raw keeps bit3", 'h024);
      // R1 / R2 faults
      sev(20, 0); cycle("R1 range send");
      sev(10, 1); cycle("R2 security send");
      sev(20, 1); cycle("R2 precedence");
      sev(4, 1); cycle("R2 allowed ns send");
      // R5 parking
      wfe(2, 7, 0); cycle("R5 park t2");
      wfe(4, 7, 0); cycle("R5 park t4");
      wfe(1, 9, 0); cycle("R5 park t1");
      wfe(1, 30, 0); cycle("R1 faulted wfe keeps state");
      wfe(1, 12, 1); cycle("R2 faulted wfe keeps state");
      // R4 / R6 release
      sev(7, 0); cycle("R3 pend 7");
      wfe(2, 7, 0); cycle("R6 release peers");
      rd("R4 raw consumed", 'h024);
      // R4 enabled line never proceeds
      sev(5, 0); cycle("R3 irq again");
      wfe(6, 5, 0); cycle("R4 enabled line blocks");
      // R9 collisions
      wr('h02C, 32'h00000020); sev(5, 0); cycle("R9 send beats clear");
      rd("R9 mis", 'h028);
      wfe(0, 3, 0); sev(3, 0); cycle("R9 send beats consume");
      rd("R9 raw", 'h024);
      wfe(3, 4, 0); cycle("R4 consume 4");
      // R8 read-only registers and unmapped offsets
      wr('h024, 32'h0); cycle("R8 raw write ignored");
      wr('h028, 32'h0); cycle("R8 mis write ignored");
      rd("R8 raw", 'h024); rd("R8 mis", 'h028);
      rd("R8 clr reads zero", 'h02C); rd("R8 unmapped", 'h000);
      wr('h02C, 32'h00000020); cycle("R7 clear irq5");
      rd("R7 mis cleared", 'h028);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule